// File: doc/BRIEF.md
# Eight-Channel Converter Register Front End

This block is the digital side of an eight-channel, 16-bit voltage-output converter. A host writes 32-bit words into it over a three-wire serial port made of a frame select (active low), a serial clock and a data line. Each word carries a command, a channel address, a 16-bit data field and an 8-bit option field. Every channel has two registers. The input register holds the next code. The DAC register holds the code that is presented at the block output. Codes move from input to DAC either by command, through an active-low load strobe, or through a per-channel override mask.

An active-low clear input acts on its falling edge. It forces the input register and the DAC register of every channel to a programmable clear code. While the clear input stays low, load activity has no effect. The block also holds a reference-enable bit and a 2-bit power-down mode for each channel. A channel that is powered down keeps its code. All serial and strobe pins are synchronized into one system clock, which runs at least four times faster than the serial clock. The serial port is a plain write-only port, so there is no back-pressure. A word that is shifted in completely is always accepted.

Top module: `octdac_ctrl`

## Requirements
- R1: While ser_sel_n is low, bits are captured on the falling edges of ser_clk, most significant bit first. After 32 edges the word is decoded as command [31:28], address [27:24], data [23:8] and option [7:0].
- R2: If ser_sel_n rises before the 32nd falling edge, the partial word is dropped and no register changes.
- R3: Command 0 writes the input register only. Command 1 copies the input register into the DAC register. Command 2 writes both. Address 15 selects all channels, addresses 0 to 7 select one channel, and any other address selects none.
- R4: While load_n is low (and clr_n is high), every DAC register tracks its input register.
- R5: Command 6 loads the override mask from option bits [7:0]. A channel whose mask bit is 1 updates its DAC register from its input register without a load strobe.
- R6: A falling edge on clr_n writes the clear code into both registers of all channels. Command 5 sets the clear code from data [1:0]: 01 gives 0x8000, 10 gives 0xFFFF, and 00 or 11 gives 0x0000. After reset the clear code gives 0x0000.
- R7: While clr_n is low, neither the load strobe nor the override mask changes any DAC register.
- R8: Command 4 writes data [1:0] as the power-down mode of every channel whose option bit is 1. The chan_on_o bit of a channel is 1 only while its mode is 00. A change of mode leaves the channel's code unchanged.
- R9: After reset, all DAC codes are 0, all modes are 00, the reference is off and the override mask is 0.
- R10: Command 7 sets ref_en_o to data bit 0.
- R11: Commands 3 and 8 to 15 change nothing.
- R12: Falling edges of ser_clk after the 32nd one, within the same frame, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_sel_n | input | 1 | Serial frame select, active low |
| ser_clk | input | 1 | Serial clock; data is captured on its falling edge |
| ser_din | input | 1 | Serial data |
| load_n | input | 1 | Load strobe, active low, level sensitive |
| clr_n | input | 1 | Clear input; acts on its falling edge and blocks loads while low |
| dac_code_o | output | 128 | DAC register codes; channel i sits at [16*i +: 16] |
| pd_mode_o | output | 16 | Power-down modes; channel i sits at [2*i +: 2] |
| chan_on_o | output | 8 | Per-channel active flags |
| ref_en_o | output | 1 | Reference enable |

## Verification
The bench builds the block with its default values: eight channels, 16-bit codes and two synchronizer stages. With eight channels, the addresses from 8 to 14 fall outside the bank, so a word sent to one of them has a visible effect of doing nothing. With 16-bit codes, the midscale and full-scale clear values are exactly 0x8000 and 0xFFFF. The serial clock runs at one sixth of the system clock, which keeps the synchronized edges cleanly separated. This makes short (aborted) frames and over-long frames easy to produce.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
  localparam int FRAME_BITS = 32;
  localparam int FLD_DATA   = 16;
  localparam int FLD_OPT    = 8;
  localparam logic [3:0] ADDR_ALL = 4'hF;

  typedef enum logic [3:0] {
    OP_WR_IN  = 4'h0,
    OP_UPD    = 4'h1,
    OP_WR_UPD = 4'h2,
    OP_PWR    = 4'h4,
    OP_CCODE  = 4'h5,
    OP_LMASK  = 4'h6,
    OP_REF    = 4'h7
  } op_e;

  typedef struct packed {
    logic [3:0]          op;
    logic [3:0]          addr;
    logic [FLD_DATA-1:0] data;
    logic [FLD_OPT-1:0]  opt;
  } frame_t;
endpackage

// File: rtl/octdac_ser_rx.sv
module octdac_ser_rx #(
  parameter int FRAME_BITS = 32,
  parameter int SYNC       = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n,
  input  logic                  sclk,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_vld_o
);
  localparam int CW = $clog2(FRAME_BITS);

  logic [SYNC-1:0] sclk_q, sel_q, din_q;
  logic            sclk_prev;
  logic [CW-1:0]   cnt;
  logic            done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '1;
      sel_q     <= '1;
      din_q     <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_q    <= {sclk_q[SYNC-2:0], sclk};
      sel_q     <= {sel_q[SYNC-2:0], sel_n};
      din_q     <= {din_q[SYNC-2:0], din};
      sclk_prev <= sclk_q[SYNC-1];
    end
  end

  logic sclk_fall, sel_s, din_s;
  assign sclk_fall = sclk_prev & ~sclk_q[SYNC-1];
  assign sel_s     = sel_q[SYNC-1];
  assign din_s     = din_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      done        <= 1'b0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      frame_vld_o <= 1'b0;
      if (sel_s) begin
        cnt  <= '0;
        done <= 1'b0;
      end else if (sclk_fall && !done) begin
        frame_o <= {frame_o[FRAME_BITS-2:0], din_s};
        if (cnt == CW'(FRAME_BITS-1)) begin
          cnt         <= '0;
          done        <= 1'b1;
          frame_vld_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/octdac_strobe.sv
module octdac_strobe #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  input  logic clr_n,
  output logic clr_fire_o,
  output logic clr_hold_o,
  output logic load_go_o
);
  logic [SYNC-1:0] load_q, clr_q;
  logic            clr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '1;
      clr_q    <= '1;
      clr_prev <= 1'b1;
    end else begin
      load_q   <= {load_q[SYNC-2:0], load_n};
      clr_q    <= {clr_q[SYNC-2:0], clr_n};
      clr_prev <= clr_q[SYNC-1];
    end
  end

  assign clr_fire_o = clr_prev & ~clr_q[SYNC-1];
  assign clr_hold_o = ~clr_q[SYNC-1];
  assign load_go_o  = ~load_q[SYNC-1] & clr_q[SYNC-1];
endmodule

// File: rtl/octdac_bank.sv
module octdac_bank
  import octdac_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  frame_t            frm,
  input  logic              frm_vld,
  input  logic              clr_fire,
  input  logic              clr_hold,
  input  logic              load_go,
  output logic [NCH*DW-1:0] dac_o,
  output logic [2*NCH-1:0]  mode_o,
  output logic              ref_o
);
  logic [1:0]     ccode_r;
  logic [NCH-1:0] mask_r;
  logic [DW-1:0]  cval;
  logic [NCH-1:0] hit;

  always_comb begin
    case (ccode_r)
      2'b01:   cval = {1'b1, {(DW-1){1'b0}}};
      2'b10:   cval = '1;
      default: cval = '0;
    endcase
  end

  always_comb begin
    for (int i = 0; i < NCH; i++)
      hit[i] = (frm.addr == ADDR_ALL) || (frm.addr == 4'(i));
  end

  logic do_wr_in, do_upd, do_wr_upd, do_pwr;
  assign do_wr_in  = frm_vld && (frm.op == OP_WR_IN);
  assign do_upd    = frm_vld && (frm.op == OP_UPD);
  assign do_wr_upd = frm_vld && (frm.op == OP_WR_UPD);
  assign do_pwr    = frm_vld && (frm.op == OP_PWR);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] in_q, dac_q;
    logic [1:0]    mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= '0;
        dac_q <= '0;
      end else if (clr_fire) begin
        in_q  <= cval;
        dac_q <= cval;
      end else begin
        if ((do_wr_in || do_wr_upd) && hit[g])
          in_q <= frm.data[DW-1:0];
        if (do_wr_upd && hit[g])
          dac_q <= frm.data[DW-1:0];
        else if (do_upd && hit[g])
          dac_q <= in_q;
        else if (!clr_hold && (load_go || mask_r[g]))
          dac_q <= in_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mode_q <= 2'b00;
      else if (do_pwr && frm.opt[g])
        mode_q <= frm.data[1:0];
    end

    assign dac_o[g*DW +: DW] = dac_q;
    assign mode_o[2*g +: 2]  = mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccode_r <= 2'b00;
      mask_r  <= '0;
      ref_o   <= 1'b0;
    end else if (frm_vld) begin
      case (frm.op)
        OP_CCODE: ccode_r <= frm.data[1:0];
        OP_LMASK: mask_r  <= frm.opt[NCH-1:0];
        OP_REF:   ref_o   <= frm.data[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
  import octdac_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              load_n,
  input  logic              clr_n,
  output logic [NCH*DW-1:0] dac_code_o,
  output logic [2*NCH-1:0]  pd_mode_o,
  output logic [NCH-1:0]    chan_on_o,
  output logic              ref_en_o
);
  logic [FRAME_BITS-1:0] frame_bits;
  logic                  frame_vld;
  logic                  clr_fire, clr_hold, load_go;

  octdac_ser_rx #(.FRAME_BITS(FRAME_BITS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel_n(ser_sel_n), .sclk(ser_clk), .din(ser_din),
    .frame_o(frame_bits), .frame_vld_o(frame_vld)
  );

  octdac_strobe #(.SYNC(SYNC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .clr_n(clr_n),
    .clr_fire_o(clr_fire), .clr_hold_o(clr_hold), .load_go_o(load_go)
  );

  octdac_bank #(.NCH(NCH), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .frm(frame_t'(frame_bits)), .frm_vld(frame_vld),
    .clr_fire(clr_fire), .clr_hold(clr_hold), .load_go(load_go),
    .dac_o(dac_code_o), .mode_o(pd_mode_o), .ref_o(ref_en_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_on
    assign chan_on_o[g] = (pd_mode_o[2*g +: 2] == 2'b00);
  end
endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_sel_n,
  input logic              load_n,
  input logic              clr_n,
  input logic [NCH*DW-1:0] dac_code_o,
  input logic [2*NCH-1:0]  pd_mode_o,
  input logic [NCH-1:0]    chan_on_o,
  input logic              ref_en_o
);
  logic [2:0] age;
  logic       warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end
  assign warm = (age == 3'd7);

  logic [NCH-1:0] same;
  logic [DW-1:0]  c0;
  assign c0 = dac_code_o[DW-1:0];
  for (genvar i = 0; i < NCH; i++) begin : g_eq
    assign same[i] = (dac_code_o[i*DW +: DW] == c0);
  end

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (dac_code_o == '0 && !ref_en_o && chan_on_o == '1);
    end
  end

  // R6
  clr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(clr_n, 3) && !$past(clr_n, 2) && !$past(clr_n) && !clr_n)
    |=> (&same && (c0 == '0 || c0 == '1 || c0 == {1'b1, {(DW-1){1'b0}}})));

  // R7
  clr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !clr_n && !$past(clr_n) && !$past(clr_n, 2) && !$past(clr_n, 3) && !$past(clr_n, 4)
     && ser_sel_n && $past(ser_sel_n) && $past(ser_sel_n, 2) && $past(ser_sel_n, 3) && $past(ser_sel_n, 4))
    |=> $stable(dac_code_o));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && ser_sel_n && $past(ser_sel_n) && $past(ser_sel_n, 2) && $past(ser_sel_n, 3) && $past(ser_sel_n, 4)
     && clr_n && $past(clr_n) && $past(clr_n, 2) && $past(clr_n, 3) && $past(clr_n, 4)
     && load_n && $past(load_n) && $past(load_n, 2) && $past(load_n, 3) && $past(load_n, 4))
    |=> ($stable(dac_code_o) && $stable(ref_en_o) && $stable(pd_mode_o)));

  for (genvar i = 0; i < NCH; i++) begin : g_pd
    // R8
    pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_on_o[i]) |-> $stable(dac_code_o[i*DW +: DW]));
  end
endmodule

bind octdac_ctrl octdac_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .load_n(load_n), .clr_n(clr_n),
  .dac_code_o(dac_code_o), .pd_mode_o(pd_mode_o), .chan_on_o(chan_on_o), .ref_en_o(ref_en_o)
);

// File: tb/octdac_ctrl_tb_top.sv
module octdac_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [127:0] dac_code_o;
  logic [15:0]  pd_mode_o;
  logic [7:0]   chan_on_o;
  logic         ref_en_o;

  always #10 clk = ~clk;

  octdac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_n(load_n), .clr_n(clr_n), .dac_code_o(dac_code_o), .pd_mode_o(pd_mode_o),
    .chan_on_o(chan_on_o), .ref_en_o(ref_en_o)
  );

  int total = 0, bad = 0;
  bit in_flight = 1'b1, finished = 1'b0;

  // behavioural model
  int in_m[8], dac_m[8], mode_m[8], cc_m;
  bit [7:0] mask_m;
  bit ref_m, load_low_m, clr_low_m;

  function automatic logic [15:0] dac_at(int c);
    return dac_code_o[c*16 +: 16];
  endfunction

  function automatic void settle_copy();
    if (!clr_low_m)
      for (int c = 0; c < 8; c++)
        if (load_low_m || mask_m[c]) dac_m[c] = in_m[c];
  endfunction

  function automatic void model_word(logic [31:0] w);
    int op, ad, dt, op_t;
    op = int'(w[31:28]); ad = int'(w[27:24]); dt = int'(w[23:8]); op_t = int'(w[7:0]);
    for (int c = 0; c < 8; c++) begin
      bit tgt;
      tgt = (ad == 15) || (ad == c);
      if (op == 0 && tgt) in_m[c] = dt;
      if (op == 1 && tgt) dac_m[c] = in_m[c];
      if (op == 2 && tgt) begin in_m[c] = dt; dac_m[c] = dt; end
      if (op == 4 && op_t[c]) mode_m[c] = dt % 4;
    end
    if (op == 5) cc_m = dt % 4;
    if (op == 6) mask_m = op_t[7:0];
    if (op == 7) ref_m = dt[0];
    settle_copy();
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && !in_flight && !finished) begin
      for (int c = 0; c < 8; c++) begin
        total++;
        if (dac_at(c) !== 16'(dac_m[c])) begin
          bad++;
          $display("FAIL R3 model ch%0d act=%h exp=%h", c, dac_at(c), 16'(dac_m[c]));
        end
        total++;
        if (pd_mode_o[2*c +: 2] !== 2'(mode_m[c]) || chan_on_o[c] !== (mode_m[c] == 0)) begin
          bad++;
          $display("FAIL R8 model ch%0d act=%b/%b exp=%0d", c, pd_mode_o[2*c +: 2], chan_on_o[c], mode_m[c]);
        end
      end
      total++;
      if (ref_en_o !== ref_m) begin
        bad++;
        $display("FAIL R10 model act=%b exp=%b", ref_en_o, ref_m);
      end
    end
  end

  task automatic send_bits(input logic [31:0] w, input int nbits);
    in_flight = 1'b1;
    @(negedge clk) ser_sel_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 32) ? w[31-i] : i[0];
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
    end
    repeat (3) @(negedge clk);
    ser_sel_n = 1'b1;
    repeat (8) @(negedge clk);
    if (nbits >= 32) model_word(w);
    in_flight = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(int op, int ad, int dt, int op_t);
    return {4'(op), 4'(ad), 16'(dt), 8'(op_t)};
  endfunction

  task automatic send(input logic [31:0] w);
    send_bits(w, 32);
  endtask

  task automatic set_load(input logic v);
    in_flight = 1'b1;
    @(negedge clk) load_n = v;
    repeat (8) @(negedge clk);
    load_low_m = !v;
    settle_copy();
    in_flight = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_clr(input logic v);
    int cv;
    in_flight = 1'b1;
    @(negedge clk) clr_n = v;
    repeat (8) @(negedge clk);
    if (!v) begin
      cv = (cc_m == 1) ? 32'h8000 : (cc_m == 2) ? 32'hFFFF : 0;
      for (int c = 0; c < 8; c++) begin in_m[c] = cv; dac_m[c] = cv; end
    end
    clr_low_m = !v;
    settle_copy();
    in_flight = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    for (int c = 0; c < 8; c++) begin in_m[c] = 0; dac_m[c] = 0; mode_m[c] = 0; end
    cc_m = 0; mask_m = '0; ref_m = 0; load_low_m = 0; clr_low_m = 0;
    repeat (5) @(negedge clk);
    chk("R9 dac zero", 32'(dac_code_o[31:0] | dac_code_o[127:96]), 32'h0);
    chk("R9 ref off", 32'(ref_en_o), 32'h0);
    chk("R9 chan on", 32'(chan_on_o), 32'hFF);
    rst_n = 1'b1;
    in_flight = 1'b0;
    repeat (3) @(negedge clk);

    send(mk(0, 2, 16'h1234, 0));
    chk("R3 input write keeps dac", 32'(dac_at(2)), 32'h0);
    send(mk(1, 2, 0, 0));
    chk("R3 update copies", 32'(dac_at(2)), 32'h1234);
    send(mk(2, 5, 16'hBEEF, 8'h5A));
    chk("R1 field layout", 32'(dac_at(5)), 32'hBEEF);
    send(mk(2, 9, 16'h7777, 0));
    chk("R3 address out of range", 32'(dac_at(5)), 32'hBEEF);
    set_clr(1'b0);
    chk("R6 default clear zero", 32'(dac_at(5)), 32'h0);
    set_clr(1'b1);
    send(mk(2, 15, 16'h0102, 0));
    chk("R3 broadcast ch0", 32'(dac_at(0)), 32'h0102);
    chk("R3 broadcast ch7", 32'(dac_at(7)), 32'h0102);
    send_bits(mk(2, 0, 16'hAAAA, 0), 20);
    chk("R2 aborted frame", 32'(dac_at(0)), 32'h0102);
    send_bits(mk(2, 1, 16'h4321, 0), 36);
    chk("R12 extra edges", 32'(dac_at(1)), 32'h4321);

    send(mk(0, 3, 16'h5555, 0));
    send(mk(0, 4, 16'h6666, 0));
    chk("R4 before strobe", 32'(dac_at(3)), 32'h0102);
    set_load(1'b0);
    chk("R4 strobe ch3", 32'(dac_at(3)), 32'h5555);
    chk("R4 strobe ch4", 32'(dac_at(4)), 32'h6666);
    set_load(1'b1);

    send(mk(6, 0, 0, 8'h01));
    send(mk(0, 0, 16'h0F0F, 0));
    chk("R5 masked channel follows", 32'(dac_at(0)), 32'h0F0F);
    send(mk(0, 6, 16'h1111, 0));
    chk("R5 unmasked channel waits", 32'(dac_at(6)), 32'h0102);
    send(mk(6, 0, 0, 8'h00));

    send(mk(5, 0, 1, 0));
    set_clr(1'b0);
    chk("R6 midscale ch6", 32'(dac_at(6)), 32'h8000);
    chk("R6 midscale ch0", 32'(dac_at(0)), 32'h8000);
    send(mk(0, 7, 16'h2222, 0));
    set_load(1'b0);
    chk("R7 strobe blocked", 32'(dac_at(7)), 32'h8000);
    set_load(1'b1);
    set_clr(1'b1);
    set_load(1'b0);
    chk("R7 strobe after release", 32'(dac_at(7)), 32'h2222);
    set_load(1'b1);
    send(mk(5, 0, 2, 0));
    set_clr(1'b0);
    chk("R6 full scale", 32'(dac_at(3)), 32'hFFFF);
    set_clr(1'b1);

    send(mk(4, 0, 2, 8'h0C));
    chk("R8 active flags", 32'(chan_on_o), 32'hF3);
    chk("R8 mode field", 32'(pd_mode_o[5:4]), 32'h2);
    chk("R8 code kept", 32'(dac_at(2)), 32'hFFFF);
    send(mk(4, 0, 0, 8'h04));
    chk("R8 power up", 32'(chan_on_o), 32'hF7);

    send(mk(7, 0, 1, 0));
    chk("R10 ref on", 32'(ref_en_o), 32'h1);
    send(mk(7, 0, 0, 0));
    chk("R10 ref off", 32'(ref_en_o), 32'h0);

    send(mk(4'hA, 15, 16'h0000, 8'hFF));
    send(mk(3, 15, 16'h1357, 8'hFF));
    chk("R11 unknown command", 32'(dac_at(3)), 32'hFFFF);
    chk("R11 modes untouched", 32'(chan_on_o), 32'hF7);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule